// File: doc/BRIEF.md
# Low-power mode transition controller

This block keeps track of the operating mode of a processor and works out where a sleep request leads. The processor can run in three modes: high-speed active, medium-speed active and sub-active. It can also be halted in one of two modes, sleep and watch. When the core executes its sleep instruction, the block reads a set of control bits, a direct-transfer interrupt enable and the global interrupt mask. From these it either halts the core, or moves it straight to another run mode through a one-state pass-through.

A direct transfer ends with a one-cycle interrupt request, so that program execution carries on in the new mode. When the move from sub-active to high-speed mode needs the main oscillator, the pass-through waits a settling time first. A 3-bit code selects that time. A halted mode is left on a wake interrupt, unless an attempted direct transfer with interrupts masked has locked it. Only reset clears that lock.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (high-speed), clk_hs_o is 1, halt_o is 0 and xfer_irq_o is 0.
- R2: In high-speed mode, a sleep strobe with standby=0, low_speed=0, med_speed=1, direct=1, xfer_irq_en=1 and int_mask=0 gives one cycle of sleep (mode_o=3). Medium-speed mode (mode_o=1) follows, with xfer_irq_o high for exactly its first cycle.
- R3: In medium-speed mode, a sleep strobe with standby=0, low_speed=0, med_speed=0, direct=1, xfer_irq_en=1 and int_mask=0 gives one cycle of sleep. High-speed mode follows, with a one-cycle xfer_irq_o.
- R4: In high-speed mode, a sleep strobe with standby=1, low_speed=1, direct=1, tmr_clk=1, xfer_irq_en=1 and int_mask=0 gives one cycle of watch (mode_o=4). Sub-active mode (mode_o=2) follows, with a one-cycle xfer_irq_o.
- R5: In sub-active mode, a sleep strobe with standby=1, low_speed=0, med_speed=0, direct=1, tmr_clk=1, xfer_irq_en=1 and int_mask=0 gives watch for exactly 8<<settle_sel cycles. High-speed mode follows, with a one-cycle xfer_irq_o.
- R6: When xfer_irq_en=0, a control combination that would otherwise transfer gives plain sleep (standby=0) or plain watch (standby=1), and xfer_irq_o stays 0.
- R7: When int_mask=1 and direct=1 at the sleep strobe, the block halts in sleep or watch according to standby. No wake_irq then leaves that mode, with int_mask set or clear, until reset.
- R8: A control combination that matches none of R2 to R5 gives sleep when standby=0 and watch when standby=1, and xfer_irq_o stays 0.
- R9: In a plain sleep, wake_irq with int_mask=0 returns the block to the run mode the sleep was entered from, one cycle later.
- R10: In a plain watch, wake_irq with int_mask=0 keeps the block in watch for 8<<settle_sel cycles. High-speed mode follows, and xfer_irq_o stays 0.
- R11: sleep_req has no effect while halted, and wake_irq has no effect in a run mode.
- R12: clk_hs_o, clk_ms_o and clk_sub_o are 1 only in mode 0, 1 and 2 respectively. halt_o is 1 only in modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe from a sleep instruction |
| ctl_standby | input | 1 | Standby select: 0 aims at sleep, 1 aims at watch |
| ctl_low_speed | input | 1 | Low-speed (sub-active) select |
| ctl_med_speed | input | 1 | Medium-speed select |
| ctl_direct | input | 1 | Direct-transfer enable |
| ctl_tmr_clk | input | 1 | Timer clock select |
| xfer_irq_en | input | 1 | Direct-transfer interrupt enable |
| int_mask | input | 1 | Global interrupt mask |
| settle_sel | input | 3 | Oscillator settling code, wait = 8<<code cycles |
| wake_irq | input | 1 | Wake interrupt |
| mode_o | output | 3 | Current mode: 0 high, 1 medium, 2 sub, 3 sleep, 4 watch |
| clk_hs_o | output | 1 | High-speed clock selected |
| clk_ms_o | output | 1 | Medium-speed clock selected |
| clk_sub_o | output | 1 | Sub clock selected |
| halt_o | output | 1 | Core halted |
| xfer_irq_o | output | 1 | Direct-transfer interrupt request |

## Verification
The bench starts from each of the three run modes and sweeps all 32 control-bit combinations. It compares every outcome with a rule table of its own. A design that mixed up a rule would land in the wrong mode, or would raise or drop the transfer interrupt at the wrong time. The settling wait is counted cycle by cycle for all eight codes, on both the direct path and the wake path. An off-by-one in the down-counter shows up as a watch one cycle too long or too short. Masked attempts and disabled interrupts are checked to halt for good or halt plainly. A missing lock would wake the core when a wake interrupt arrives.

// File: rtl/pwrmode_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and the decision record passed from the
// transfer decoder to the sequencer. Assumes 3-bit mode codes.
package pwrmode_pkg;

    typedef enum logic [2:0] {
        M_HS  = 3'd0,
        M_MS  = 3'd1,
        M_SUB = 3'd2,
        M_SLP = 3'd3,
        M_WAT = 3'd4
    } mode_e;

    localparam int NUM_RUN = 3;

    typedef struct packed {
        mode_e via;     // halted or pass-through mode entered first
        mode_e target;  // run mode reached after a direct transfer
        logic  direct;  // a direct transfer is taken
        logic  settle;  // the pass-through waits for the oscillator
        logic  lock;    // masked transfer attempt: no wake allowed
    } xfer_t;

endpackage

// File: rtl/pwrmode_decide.sv
`timescale 1ns/1ps
// Module: pwrmode_decide
// Purely combinational. From the current run mode and the control bits it
// decides what a sleep strobe does. Assumes the caller only uses the result
// while in a run mode and on a sleep strobe.
module pwrmode_decide
    import pwrmode_pkg::*;
(
    input  mode_e cur_mode,
    input  logic  standby,
    input  logic  low_speed,
    input  logic  med_speed,
    input  logic  direct,
    input  logic  tmr_clk,
    input  logic  irq_en,
    input  logic  mask,
    output xfer_t plan
);

    logic  match;
    mode_e tgt;
    logic  take;

    // Rule table: find which direct path, if any, the bits select.
    always_comb begin
        match = 1'b0;
        tgt   = M_HS;
        unique case (cur_mode)
            M_HS: begin
                if (standby && low_speed && tmr_clk) begin
                    match = 1'b1;
                    tgt   = M_SUB;
                end else if (!standby && !low_speed && med_speed) begin
                    match = 1'b1;
                    tgt   = M_MS;
                end
            end
            M_MS: begin
                if (!standby && !low_speed && !med_speed) begin
                    match = 1'b1;
                    tgt   = M_HS;
                end
            end
            M_SUB: begin
                if (standby && !low_speed && !med_speed && tmr_clk) begin
                    match = 1'b1;
                    tgt   = M_HS;
                end
            end
            default: begin
                match = 1'b0;
                tgt   = M_HS;
            end
        endcase
    end

    // Gating: a transfer needs the enable bit, the interrupt enable and an
    // open interrupt mask.
    always_comb begin
        take        = direct && match && irq_en && !mask;
        plan.direct = take;
        plan.target = tgt;
        plan.settle = take && (cur_mode == M_SUB);
        plan.lock   = direct && mask;
        if (take)
            plan.via = (tgt == M_SUB || cur_mode == M_SUB) ? M_WAT : M_SLP;
        else
            plan.via = standby ? M_WAT : M_SLP;
    end

endmodule

// File: rtl/pwrmode_settle.sv
`timescale 1ns/1ps
// Module: pwrmode_settle
// Down-counter for the oscillator settling wait. A load sets it to
// (1 << (BASE_LOG2 + sel)) - 1, and it counts down while run is high.
// done is raised in the last cycle of the wait, so a caller that leaves
// on done spends exactly 1 << (BASE_LOG2 + sel) cycles waiting.
// Assumes load and the countdown never overlap.
module pwrmode_settle #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             done
);

    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Load value from the settling code.
    always_comb begin
        load_val = (CNT_W'(1) << (BASE_LOG2 + int'(sel))) - CNT_W'(1);
    end

    // Counter register: load, count down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Completion flag for the sequencer.
    assign done = run && (cnt_q == '0);

    // R5: once loaded, the counter falls by one each running cycle
    p_count_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R10: a load never leaves a zero count (the wait is at least 8 cycles)
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/pwrmode_ctrl.sv
`timescale 1ns/1ps
// Module: pwrmode_ctrl (top)
// Mode sequencer. In a run mode it acts on a sleep strobe, using the
// decoder's decision. In sleep or watch it either completes a one-cycle
// pass-through, runs the settling wait, or waits for an unmasked wake.
// Assumes sleep_req is a single-cycle strobe and inputs are synchronous.
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             ctl_standby,
    input  logic             ctl_low_speed,
    input  logic             ctl_med_speed,
    input  logic             ctl_direct,
    input  logic             ctl_tmr_clk,
    input  logic             xfer_irq_en,
    input  logic             int_mask,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             wake_irq,
    output logic [2:0]       mode_o,
    output logic             clk_hs_o,
    output logic             clk_ms_o,
    output logic             clk_sub_o,
    output logic             halt_o,
    output logic             xfer_irq_o
);

    mode_e mode_q;
    mode_e origin_q;
    mode_e target_q;
    logic  pass_q;
    logic  lock_q;
    logic  settle_q;
    logic  irq_q;

    xfer_t plan;
    logic  in_run;
    logic  wake_ok;
    logic  cnt_load;
    logic  cnt_done;
    logic [NUM_RUN-1:0] run_sel;

    // Decision for a sleep strobe in the current run mode.
    pwrmode_decide u_decide (
        .cur_mode  (mode_q),
        .standby   (ctl_standby),
        .low_speed (ctl_low_speed),
        .med_speed (ctl_med_speed),
        .direct    (ctl_direct),
        .tmr_clk   (ctl_tmr_clk),
        .irq_en    (xfer_irq_en),
        .mask      (int_mask),
        .plan      (plan)
    );

    // Run or halt classification, and whether a wake may be honoured.
    always_comb begin
        in_run  = (mode_q == M_HS) || (mode_q == M_MS) || (mode_q == M_SUB);
        wake_ok = wake_irq && !int_mask && !lock_q && !pass_q;
    end

    // Counter load: a direct transfer out of sub-active, or a wake from watch.
    always_comb begin
        cnt_load = (in_run && sleep_req && plan.settle) ||
                   (mode_q == M_WAT && !settle_q && wake_ok);
    end

    pwrmode_settle #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .sel   (settle_sel),
        .run   (settle_q),
        .done  (cnt_done)
    );

    // Mode sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_HS;
            origin_q <= M_HS;
            target_q <= M_HS;
            pass_q   <= 1'b0;
            lock_q   <= 1'b0;
            settle_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (mode_q)
                M_HS, M_MS, M_SUB: begin
                    if (sleep_req) begin
                        mode_q   <= plan.via;
                        origin_q <= mode_q;
                        target_q <= plan.target;
                        pass_q   <= plan.direct;
                        lock_q   <= plan.lock;
                        settle_q <= plan.settle;
                    end
                end
                M_SLP: begin
                    if (pass_q) begin
                        mode_q <= target_q;
                        pass_q <= 1'b0;
                        irq_q  <= 1'b1;
                    end else if (wake_ok) begin
                        mode_q <= origin_q;
                    end
                end
                M_WAT: begin
                    if (settle_q) begin
                        if (cnt_done) begin
                            mode_q   <= M_HS;
                            settle_q <= 1'b0;
                            pass_q   <= 1'b0;
                            irq_q    <= pass_q;
                        end
                    end else if (pass_q) begin
                        mode_q <= target_q;
                        pass_q <= 1'b0;
                        irq_q  <= 1'b1;
                    end else if (wake_ok) begin
                        settle_q <= 1'b1;
                    end
                end
                default: begin
                    mode_q <= M_HS;
                end
            endcase
        end
    end

    // One clock-select line per run mode.
    for (genvar i = 0; i < NUM_RUN; i++) begin : g_clk_sel
        assign run_sel[i] = (mode_q == mode_e'(3'(i)));
    end

    assign mode_o     = mode_q;
    assign clk_hs_o   = run_sel[0];
    assign clk_ms_o   = run_sel[1];
    assign clk_sub_o  = run_sel[2];
    assign halt_o     = (mode_q == M_SLP) || (mode_q == M_WAT);
    assign xfer_irq_o = irq_q;

    // R2: a transfer interrupt only follows a halted cycle
    p_irq_after_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq_o |-> $past(halt_o));

    // R2: the transfer interrupt is raised while running, never halted
    p_irq_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq_o |-> !halt_o);

    // R2: a pass-through sleep lasts one cycle
    p_pass_sleep_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SLP && pass_q) |=> !halt_o);

    // R7: a locked halt stays halted
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && halt_o) |=> halt_o);

    // R8: leaving a plain halt never raises the transfer interrupt
    p_no_irq_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !pass_q) |=> !xfer_irq_o);

    // R12: exactly one of the clock selects and the halt flag is active
    p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({clk_hs_o, clk_ms_o, clk_sub_o, halt_o}));

endmodule

// File: tb/pwrmode_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: sweeps control combinations from each run mode against a rule
// table of its own, and counts the settling waits for all codes.
module pwrmode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_req, sb, ls, ms, dr, tm, irq_en, mask, wake;
    logic [2:0] sel;
    logic [2:0] mode_o;
    logic       clk_hs_o, clk_ms_o, clk_sub_o, halt_o, xfer_irq_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    localparam int HS = 0, MS = 1, SUB = 2, SLP = 3, WAT = 4;

    always #2.5 clk = ~clk;

    pwrmode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .ctl_standby(sb), .ctl_low_speed(ls), .ctl_med_speed(ms),
        .ctl_direct(dr), .ctl_tmr_clk(tm), .xfer_irq_en(irq_en),
        .int_mask(mask), .settle_sel(sel), .wake_irq(wake),
        .mode_o(mode_o), .clk_hs_o(clk_hs_o), .clk_ms_o(clk_ms_o),
        .clk_sub_o(clk_sub_o), .halt_o(halt_o), .xfer_irq_o(xfer_irq_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_req = 0; wake = 0; sb = 0; ls = 0; ms = 0;
        dr = 0; tm = 0; irq_en = 1; mask = 0; sel = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_sleep(bit b_sb, bit b_ls, bit b_ms, bit b_dr, bit b_tm);
        sb = b_sb; ls = b_ls; ms = b_ms; dr = b_dr; tm = b_tm;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    // Counts consecutive watch samples, starting with the current one.
    task automatic count_watch(output int n);
        n = (mode_o == 3'(WAT)) ? 1 : 0;
        while (mode_o == 3'(WAT) && n < 5000) begin
            @(negedge clk);
            if (mode_o == 3'(WAT)) n++;
        end
    endtask

    // Bench rule table: direct target, or -1 for none.
    function automatic int rule(int org, bit b_sb, bit b_ls, bit b_ms, bit b_dr, bit b_tm);
        if (!b_dr) return -1;
        if (org == HS && b_sb && b_ls && b_tm) return SUB;
        if (org == HS && !b_sb && !b_ls && b_ms) return MS;
        if (org == MS && !b_sb && !b_ls && !b_ms) return HS;
        if (org == SUB && b_sb && !b_ls && !b_ms && b_tm) return HS;
        return -1;
    endfunction

    task automatic go_to(int org);
        do_reset();
        if (org == MS) begin
            pulse_sleep(0, 0, 1, 1, 0);
            repeat (2) @(negedge clk);
        end else if (org == SUB) begin
            pulse_sleep(1, 1, 0, 1, 1);
            repeat (2) @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int d;
        string tag;

        // R1: reset state, also after a reset taken mid-operation
        do_reset();
        check("R1 mode", int'(mode_o), HS);
        check("R1 clk_hs", int'(clk_hs_o), 1);
        check("R1 halt", int'(halt_o), 0);
        check("R1 irq", int'(xfer_irq_o), 0);
        pulse_sleep(0, 0, 0, 0, 0);
        check("R8 plain sleep", int'(mode_o), SLP);
        do_reset();
        check("R1 mode after reset from sleep", int'(mode_o), HS);

        // Sweep: every run mode and all 32 control combinations
        for (int org = 0; org < 3; org++) begin
            for (int c = 0; c < 32; c++) begin
                bit b_sb, b_ls, b_ms, b_dr, b_tm;
                {b_sb, b_ls, b_ms, b_dr, b_tm} = 5'(c);
                go_to(org);
                check("R12 start mode", int'(mode_o), org);
                pulse_sleep(b_sb, b_ls, b_ms, b_dr, b_tm);
                d = rule(org, b_sb, b_ls, b_ms, b_dr, b_tm);
                if (d >= 0) begin
                    tag = (org == SUB) ? "R5" : (org == MS) ? "R3" :
                          (d == SUB) ? "R4" : "R2";
                    check({tag, " pass-through mode"}, int'(mode_o),
                          (d == SUB || org == SUB) ? WAT : SLP);
                    check("R12 halt in pass-through", int'(halt_o), 1);
                    if (org == SUB) begin
                        count_watch(n);
                        check("R5 watch length code 0", n, 8);
                    end else begin
                        @(negedge clk);
                    end
                    check({tag, " arrival mode"}, int'(mode_o), d);
                    check({tag, " irq on arrival"}, int'(xfer_irq_o), 1);
                    @(negedge clk);
                    check({tag, " irq one cycle"}, int'(xfer_irq_o), 0);
                end else begin
                    check("R8 halted mode", int'(mode_o), b_sb ? WAT : SLP);
                    check("R8 no irq", int'(xfer_irq_o), 0);
                    pulse_wake();
                    if (!b_sb) begin
                        check("R9 wake returns to origin", int'(mode_o), org);
                    end else begin
                        count_watch(n);
                        check("R10 wake watch length", n, 8);
                        check("R10 wake lands high-speed", int'(mode_o), HS);
                    end
                    check("R10 no irq after wake", int'(xfer_irq_o), 0);
                end
            end
        end

        // R5: settling length for every code on the direct path
        for (int s = 0; s < 8; s++) begin
            go_to(SUB);
            sel = 3'(s);
            pulse_sleep(1, 0, 0, 1, 1);
            count_watch(n);
            check("R5 settle length", n, 8 << s);
            check("R5 irq after settle", int'(xfer_irq_o), 1);
        end

        // R10: settling length for every code on the wake path
        for (int s = 0; s < 8; s++) begin
            go_to(HS);
            pulse_sleep(1, 0, 0, 0, 0);
            sel = 3'(s);
            pulse_wake();
            count_watch(n);
            check("R10 wake settle length", n, 8 << s);
            check("R10 mode after settle", int'(mode_o), HS);
        end

        // R6: interrupt enable cleared turns each transfer into a plain halt
        go_to(HS); irq_en = 0;
        pulse_sleep(0, 0, 1, 1, 0);
        check("R6 sleep instead of medium", int'(mode_o), SLP);
        @(negedge clk);
        check("R6 still sleeping", int'(mode_o), SLP);
        check("R6 no irq", int'(xfer_irq_o), 0);
        pulse_wake();
        check("R6 wake back to high", int'(mode_o), HS);
        go_to(HS); irq_en = 0;
        pulse_sleep(1, 1, 0, 1, 1);
        @(negedge clk);
        check("R6 watch instead of sub", int'(mode_o), WAT);
        go_to(SUB); irq_en = 0;
        pulse_sleep(1, 0, 0, 1, 1);
        repeat (20) @(negedge clk);
        check("R6 watch kept from sub", int'(mode_o), WAT);

        // R7: masked transfer attempts lock the halt
        go_to(HS); mask = 1;
        pulse_sleep(0, 0, 1, 1, 0);
        check("R7 masked sleep", int'(mode_o), SLP);
        pulse_wake();
        check("R7 wake with mask ignored", int'(mode_o), SLP);
        mask = 0;
        pulse_wake();
        repeat (2) @(negedge clk);
        check("R7 wake after unmask ignored", int'(mode_o), SLP);
        go_to(MS); mask = 1;
        pulse_sleep(1, 1, 0, 1, 1);
        mask = 0;
        pulse_wake();
        repeat (40) @(negedge clk);
        check("R7 masked watch locked", int'(mode_o), WAT);
        do_reset();
        check("R7 reset releases lock", int'(mode_o), HS);

        // R11: sleep strobe while halted, wake while running
        go_to(HS);
        pulse_sleep(0, 1, 0, 0, 0);
        pulse_sleep(0, 0, 1, 1, 0);
        @(negedge clk);
        check("R11 sleep strobe while halted", int'(mode_o), SLP);
        check("R11 no irq while halted", int'(xfer_irq_o), 0);
        go_to(MS);
        pulse_wake();
        @(negedge clk);
        check("R11 wake in run mode", int'(mode_o), MS);
        check("R12 medium clock select", int'(clk_ms_o), 1);
        go_to(SUB);
        check("R12 sub clock select", int'(clk_sub_o), 1);
        check("R12 high clock off in sub", int'(clk_hs_o), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule